// File: doc/BRIEF.md
# Single-Vector Interrupt Request Controller

This block collects interrupt events for a small 8-bit processor core. There are three sources: an external pin and two timer event pulses. Each event latches into a sticky request flag. A second register holds one enable bit per source. When a flag and its enable are both set, the block asks the core for an interrupt. Every interrupt sends the core to the same fixed vector address. The service code then reads the flag register to find which source fired.

Both registers sit on a byte-wide register bus. Writes take effect at the clock edge, and reads are combinational. Taking an interrupt does not clear any flag; software clears a flag by writing 0 to it.

An in-service bit is set when the core acknowledges the request. It stays set until the core sends a one-cycle return strobe. While it is set, no new request goes out, so interrupts do not nest.

Top module: `vec_irq_unit`

## Requirements
- R1: After reset, both registers read 0x00 and `core_irq_req` is low.
- R2: The flag register is at bus address 0xC8 and the enable register at 0xC9. In both, bit 0 is the external pin, bit 5 is timer 0 and bit 6 is timer 1. Any other address reads 0x00, and a write to it changes nothing.
- R3: Bits 1 to 4 and bit 7 of both registers always read 0, and writing 1 to them has no effect.
- R4: A one-cycle pulse on `tmr0_evt` or `tmr1_evt` sets flag bit 5 or 6 at the next rising edge, whether or not its enable bit is set.
- R5: A falling edge on `ext_pin` sets flag bit 0, which is readable after the third rising edge that follows the pin going low. A rising edge on the pin sets nothing.
- R6: `core_irq_req` is high exactly when some bit is 1 in both the flag and enable registers and the block is not in service. A flag with a cleared enable never raises the request.
- R7: `core_vector` always carries 0x008.
- R8: Flags are not cleared by an acknowledge. A flag is cleared only by writing 0 to it at 0xC8.
- R9: If a source event and a write of 0 to the same flag happen in the same cycle, the flag ends up 1.
- R10: An acknowledge while the request is high puts the block in service, and the request stays low until `core_reti` is pulsed. In the cycle after the strobe, the request is high again if any enabled flag is still set.
- R11: Writing 1 to an implemented flag bit sets that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| ext_pin | input | 1 | Asynchronous external interrupt pin, idle high |
| tmr0_evt | input | 1 | Timer 0 event pulse |
| tmr1_evt | input | 1 | Timer 1 event pulse |
| core_irq_req | output | 1 | Interrupt request to the core |
| core_irq_ack | input | 1 | Core acknowledges the request |
| core_reti | input | 1 | One-cycle return-from-interrupt strobe |
| core_vector | output | 12 | Fixed vector address |

## Verification
Each result has a known latency:
- Register writes and timer pulses show up in the flags and enables after one rising edge.
- The external pin needs three edges: two synchronizer stages and the flag register.
- `bus_rdata`, `core_irq_req` and `core_vector` follow the register state combinationally, with no extra delay.

The bench therefore drives inputs on the falling edge and removes them after the next rising edge. It reads results just after the following falling edge. For the pin, it checks the flag after the second edge (still clear) and after the third edge (set), which pins down the exact latency.

// File: rtl/vec_irq_pkg.sv
`timescale 1ns/1ps
package vec_irq_pkg;

   localparam int NSRC = 3;

   typedef enum int {
      SRC_PIN  = 0,
      SRC_TMR0 = 1,
      SRC_TMR1 = 2
   } src_e;

   // register bit that each source occupies (same in flag and enable)
   function automatic int src_bit(input int src);
      case (src)
         SRC_PIN:  return 0;
         SRC_TMR0: return 5;
         SRC_TMR1: return 6;
         default:  return -1;
      endcase
   endfunction

   // source index held by a register bit, or -1 when the bit is unused
   function automatic int bit_src(input int b);
      for (int s = 0; s < NSRC; s++) begin
         if (src_bit(s) == b) return s;
      end
      return -1;
   endfunction

   function automatic int max_bit();
      int m = 0;
      for (int s = 0; s < NSRC; s++) begin
         if (src_bit(s) > m) m = src_bit(s);
      end
      return m;
   endfunction

endpackage

// File: rtl/vec_irq_fall_det.sv
`timescale 1ns/1ps
module vec_irq_fall_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic fall_pulse
);

   // synchronizer chain plus one history flop; all reset to the idle-high level
   logic [STAGES:0] chain_q;

   genvar g;
   generate
      for (g = 0; g <= STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= pin_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b1;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign fall_pulse = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/vec_irq_regs.sv
`timescale 1ns/1ps
module vec_irq_regs
   import vec_irq_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 8,
   parameter logic [7:0]  FLAG_ADDR = 8'hC8,
   parameter logic [7:0]  ENAB_ADDR = 8'hC9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [NSRC-1:0]   src_evt,
   output logic [DATA_W-1:0] flag_q,
   output logic [DATA_W-1:0] en_q,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(FLAG_ADDR);
   localparam logic [ADDR_W-1:0] ENAB_A = ADDR_W'(ENAB_ADDR);

   logic hit_flag, hit_enab;
   assign hit_flag = (bus_addr == FLAG_A);
   assign hit_enab = (bus_addr == ENAB_A);

   logic wr_flag, wr_enab;
   assign wr_flag = bus_wr & hit_flag;
   assign wr_enab = bus_wr & hit_enab;

   logic [DATA_W-1:0] unused_wdata_bits;

   genvar b;
   generate
      for (b = 0; b < DATA_W; b++) begin : g_bit
         localparam int SI = bit_src(b);
         if (SI >= 0) begin : g_impl
            // event wins over a clearing write in the same cycle
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       flag_q[b] <= 1'b0;
               else if (wr_flag) flag_q[b] <= bus_wdata[b] | src_evt[SI];
               else              flag_q[b] <= flag_q[b] | src_evt[SI];
            end
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       en_q[b] <= 1'b0;
               else if (wr_enab) en_q[b] <= bus_wdata[b];
            end
            assign unused_wdata_bits[b] = 1'b0;
         end else begin : g_none
            assign flag_q[b] = 1'b0;
            assign en_q[b]   = 1'b0;
            assign unused_wdata_bits[b] = bus_wdata[b];
         end
      end
   endgenerate

   always_comb begin
      if (hit_flag)      rdata = flag_q;
      else if (hit_enab) rdata = en_q;
      else               rdata = '0;
   end

endmodule

// File: rtl/vec_irq_svc.sv
`timescale 1ns/1ps
module vec_irq_svc (
   input  logic clk,
   input  logic rst_n,
   input  logic pending,
   input  logic ack,
   input  logic reti,
   output logic req,
   output logic in_svc
);

   assign req = pending & ~in_svc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          in_svc <= 1'b0;
      else if (ack && req) in_svc <= 1'b1;
      else if (reti)       in_svc <= 1'b0;
   end

endmodule

// File: rtl/vec_irq_unit.sv
`timescale 1ns/1ps
module vec_irq_unit
   import vec_irq_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 8,
   parameter int          VEC_W       = 12,
   parameter logic [7:0]  FLAG_ADDR   = 8'hC8,
   parameter logic [7:0]  ENAB_ADDR   = 8'hC9,
   parameter logic [11:0] VEC_ADDR    = 12'h008,
   parameter int          SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ext_pin,
   input  logic              tmr0_evt,
   input  logic              tmr1_evt,
   output logic              core_irq_req,
   input  logic              core_irq_ack,
   input  logic              core_reti,
   output logic [VEC_W-1:0]  core_vector
);

   generate
      if (DATA_W <= max_bit()) begin : g_bad_width
         $error("vec_irq_unit: DATA_W too narrow for the source bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("vec_irq_unit: SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("vec_irq_unit: ADDR_W must hold the register addresses");
      end
   endgenerate

   logic              pin_fall;
   logic [NSRC-1:0]   src_evt;
   logic [DATA_W-1:0] flag_q;
   logic [DATA_W-1:0] en_q;
   logic              in_svc;
   logic              pending;

   vec_irq_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_in     (ext_pin),
      .fall_pulse (pin_fall)
   );

   always_comb begin
      src_evt           = '0;
      src_evt[SRC_PIN]  = pin_fall;
      src_evt[SRC_TMR0] = tmr0_evt;
      src_evt[SRC_TMR1] = tmr1_evt;
   end

   vec_irq_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .FLAG_ADDR (FLAG_ADDR),
      .ENAB_ADDR (ENAB_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .src_evt   (src_evt),
      .flag_q    (flag_q),
      .en_q      (en_q),
      .rdata     (bus_rdata)
   );

   assign pending = |(flag_q & en_q);

   vec_irq_svc u_svc (
      .clk     (clk),
      .rst_n   (rst_n),
      .pending (pending),
      .ack     (core_irq_ack),
      .reti    (core_reti),
      .req     (core_irq_req),
      .in_svc  (in_svc)
   );

   assign core_vector = VEC_W'(VEC_ADDR);

endmodule

// File: rtl/vec_irq_chk.sv
`timescale 1ns/1ps
module vec_irq_chk
   import vec_irq_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter int         DATA_W    = 8,
   parameter logic [7:0] FLAG_ADDR = 8'hC8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              tmr0_evt,
   input logic              tmr1_evt,
   input logic              core_irq_req,
   input logic              core_irq_ack,
   input logic [DATA_W-1:0] flag_q,
   input logic [DATA_W-1:0] en_q,
   input logic              in_svc
);

   localparam int B_T0 = src_bit(SRC_TMR0);
   localparam int B_T1 = src_bit(SRC_TMR1);

   // R4
   tmr0_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr0_evt |=> flag_q[B_T0]);

   // R9
   event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr1_evt && bus_wr && bus_addr == ADDR_W'(FLAG_ADDR)) |=> flag_q[B_T1]);

   // R8
   ack_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_irq_ack && core_irq_req && !bus_wr) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   // R10
   no_nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_svc |-> !core_irq_req);

   // R10
   enter_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_irq_ack && core_irq_req) |=> in_svc);

   // R6
   req_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(flag_q & en_q)) && !in_svc) |-> core_irq_req);

   // R6
   req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_irq_req |-> (|(flag_q & en_q)));

endmodule

bind vec_irq_unit vec_irq_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .FLAG_ADDR (FLAG_ADDR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_wr       (bus_wr),
   .tmr0_evt     (tmr0_evt),
   .tmr1_evt     (tmr1_evt),
   .core_irq_req (core_irq_req),
   .core_irq_ack (core_irq_ack),
   .flag_q       (flag_q),
   .en_q         (en_q),
   .in_svc       (in_svc)
);

// File: tb/test_vec_irq_unit.sv
`timescale 1ns/1ps
module test_vec_irq_unit;

   localparam logic [7:0] A_FLAG = 8'hC8;
   localparam logic [7:0] A_ENAB = 8'hC9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ext_pin = 1'b1;
   logic       tmr0_evt = 1'b0;
   logic       tmr1_evt = 1'b0;
   logic       core_irq_req;
   logic       core_irq_ack = 1'b0;
   logic       core_reti = 1'b0;
   logic [11:0] core_vector;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   vec_irq_unit i_vec_irq_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .ext_pin      (ext_pin),
      .tmr0_evt     (tmr0_evt),
      .tmr1_evt     (tmr1_evt),
      .core_irq_req (core_irq_req),
      .core_irq_ack (core_irq_ack),
      .core_reti    (core_reti),
      .core_vector  (core_vector)
   );

   typedef struct packed {
      logic       wr;
      logic [7:0] addr;
      logic [7:0] wdata;
      logic       t0;
      logic       t1;
      logic [7:0] exp_flag;
      logic [7:0] exp_en;
      logic       exp_req;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 8'hC9, 8'hFF, 1'b0, 1'b0, 8'h00, 8'h61, 1'b0}, // R3 enable write, unused bits dropped
      '{1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h20, 8'h61, 1'b1}, // R4 timer 0 pulse
      '{1'b1, 8'hC8, 8'h00, 1'b0, 1'b0, 8'h00, 8'h61, 1'b0}, // R8 software clear
      '{1'b1, 8'hC9, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0}, // R2 enables off
      '{1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h40, 8'h00, 1'b0}, // R6 flag without enable
      '{1'b1, 8'hC9, 8'h40, 1'b0, 1'b0, 8'h40, 8'h40, 1'b1}, // R6 enable makes request
      '{1'b1, 8'hC8, 8'h00, 1'b0, 1'b1, 8'h40, 8'h40, 1'b1}, // R9 event beats clear
      '{1'b1, 8'hC8, 8'hFF, 1'b0, 1'b0, 8'h61, 8'h40, 1'b1}, // R11 software set
      '{1'b1, 8'hC8, 8'h00, 1'b0, 1'b0, 8'h00, 8'h40, 1'b0}, // R8 clear all
      '{1'b1, 8'h10, 8'hFF, 1'b0, 1'b0, 8'h00, 8'h40, 1'b0}, // R2 other address ignored
      '{1'b1, 8'hC9, 8'h01, 1'b0, 1'b0, 8'h00, 8'h01, 1'b0}  // R2 pin enable
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 8'h00;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      while (cyc < 20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
      finish_run();
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R7 vector
      read_reg(A_FLAG, rd); check("R1 flags after reset", 16'(rd), 16'h00);
      read_reg(A_ENAB, rd); check("R1 enables after reset", 16'(rd), 16'h00);
      check("R1 request after reset", 16'(core_irq_req), 16'h0);
      check("R7 vector", 16'(core_vector), 16'h008);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         bus_wr = TBL[i].wr; bus_addr = TBL[i].addr; bus_wdata = TBL[i].wdata;
         tmr0_evt = TBL[i].t0; tmr1_evt = TBL[i].t1;
         @(posedge clk);
         @(negedge clk);
         bus_wr = 1'b0; bus_wdata = 8'h00; tmr0_evt = 1'b0; tmr1_evt = 1'b0;
         read_reg(A_FLAG, rd); check($sformatf("R2 table %0d flags", i), 16'(rd), 16'(TBL[i].exp_flag));
         read_reg(A_ENAB, rd); check($sformatf("R3 table %0d enables", i), 16'(rd), 16'(TBL[i].exp_en));
         check($sformatf("R6 table %0d request", i), 16'(core_irq_req), 16'(TBL[i].exp_req));
      end

      read_reg(8'h10, rd); check("R2 unmapped address reads zero", 16'(rd), 16'h00);

      // R5 falling edge on pin: flag after third edge
      @(negedge clk);
      ext_pin = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      read_reg(A_FLAG, rd); check("R5 pin flag not yet set after two edges", 16'(rd), 16'h00);
      @(posedge clk);
      @(negedge clk);
      read_reg(A_FLAG, rd); check("R5 pin flag set after third edge", 16'(rd), 16'h01);
      check("R6 request from pin", 16'(core_irq_req), 16'h1);

      // R10 acknowledge enters service, R8 flag survives
      @(negedge clk);
      core_irq_ack = 1'b1;
      @(posedge clk);
      @(negedge clk);
      core_irq_ack = 1'b0;
      check("R10 request low in service", 16'(core_irq_req), 16'h0);
      read_reg(A_FLAG, rd); check("R8 flag kept after ack", 16'(rd), 16'h01);
      check("R7 vector during service", 16'(core_vector), 16'h008);

      // R5 rising edge sets nothing
      reg_write(A_FLAG, 8'h00);
      ext_pin = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      read_reg(A_FLAG, rd); check("R5 rising pin edge ignored", 16'(rd), 16'h00);

      // R10 pending flag held off until return strobe
      reg_write(A_FLAG, 8'h01);
      check("R10 no request while in service", 16'(core_irq_req), 16'h0);
      @(negedge clk);
      core_reti = 1'b1;
      @(posedge clk);
      @(negedge clk);
      core_reti = 1'b0;
      check("R10 request after return strobe", 16'(core_irq_req), 16'h1);

      // R1 reset clears everything again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      read_reg(A_FLAG, rd); check("R1 flags after second reset", 16'(rd), 16'h00);
      read_reg(A_ENAB, rd); check("R1 enables after second reset", 16'(rd), 16'h00);
      check("R1 request after second reset", 16'(core_irq_req), 16'h0);

      finish_run();
   end

endmodule